// File: doc/BRIEF.md
# Adaptive Hybrid Cache Remapper

This block steers scratchpad capacity around a set-associative cache where a few ways in some sets are held as scratchpad blocks instead of normal lines. These blocks float. When a set takes many misses and also holds a floating block, the block is moved to a set that sees few misses. The way it left becomes a normal cache way again. The set that takes the block gives up one of its cache lines to make room.

Miss events come in with a set index. Each set has a saturating miss counter, and every counter is cleared at the end of each adaptation interval. A holder list keeps one entry per floating block: the set and way where the block now sits, and a flag that marks whether the block has already moved during this interval. A block that has moved stays pinned in its new set until the interval ends. This stops a block from bouncing back and forth between two sets. Each relocation goes out as one command on a valid/ready handshake to the cache array. The current position of every scratchpad way is also published as a per-set way-mode map.

Top module: `hybrid_cache_remapper`

## Requirements
- R1: After reset `cmd_valid` is 0. Floating block k (k < FLOAT_BLOCKS) sits in set k, way WAYS-1. Bit `set*WAYS+way` of `way_mode` is 1 exactly for the ways that hold a block, and the number of 1 bits always equals FLOAT_BLOCKS.
- R2: Only a cycle with `ev_valid`=1 and `ev_miss`=1 adds one to the miss count of `ev_set`. A set is hot when its count is at least HOT_TH. Hits and invalid cycles change nothing.
- R3: The destination is the lowest-numbered set that is not the source, has a count of at most COLD_TH, and holds fewer than MAX_SPM scratchpad ways. If no set qualifies, no command is issued.
- R4: The source is the floating block with the lowest entry index that sits in a hot set and is not pinned. `cmd_src_set` and `cmd_src_way` give its current place.
- R5: `cmd_dst_way` is the destination set's value on `lru_way` if that way is a cache way. Otherwise it is the lowest-numbered cache way of the destination set.
- R6: While `cmd_valid`=1 and `cmd_ready`=0, the command and all its fields stay unchanged. After an accept, `cmd_valid` is 0 for at least one cycle, so at most one command is outstanding.
- R7: In the cycle after an accept, `way_mode` shows the source way as a cache way and the destination way as a scratchpad way.
- R8: A block that has moved during the current interval is not chosen again until the interval ends, even if its set is hot.
- R9: Every INTERVAL cycles after reset, all miss counts and all pins are cleared. Misses from two intervals never add together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Access event present |
| ev_miss | input | 1 | Event was a miss |
| ev_set | input | SET_W | Set index of the event |
| lru_way | input | NUM_SETS*WAY_W | Preferred victim way for each set, set s at bits s*WAY_W |
| cmd_valid | output | 1 | Relocation command pending |
| cmd_ready | input | 1 | Cache array accepts the command |
| cmd_src_set | output | SET_W | Set that gives up the block |
| cmd_src_way | output | WAY_W | Way freed back to the cache |
| cmd_dst_set | output | SET_W | Set that receives the block |
| cmd_dst_way | output | WAY_W | Line that the receiving set evicts |
| way_mode | output | NUM_SETS*WAYS | 1 marks a scratchpad way, bit set*WAYS+way |

## Verification
The assertions check these properties on every cycle:
- the number of scratchpad ways never changes;
- a pending command keeps its fields while it is stalled;
- a pending command always names a source way that holds scratchpad and a destination way that is a cache way, in two different sets;
- an accept shows up in the map one cycle later, and the command line goes idle after it.

Some behaviour only the bench scenarios can show: whether the chosen source and destination sets are the right ones, the counting thresholds, the way pinning blocks a second move, and the way an interval boundary clears both counts and pins.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
   // Default sizing shared by the remapper and its helpers.
   localparam int HCR_DEF_SETS     = 64;
   localparam int HCR_DEF_WAYS     = 8;
   localparam int HCR_DEF_FLOATS   = 16;
   localparam int HCR_DEF_INTERVAL = 1000000;

   // Width of an index that must address n items, never below one bit.
   function automatic int hcr_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/hcr_miss_track.sv
module hcr_miss_track #(
   parameter int NUM_SETS = 64,
   parameter int SET_W    = 6,
   parameter int CNT_W    = 4,
   parameter int HOT_TH   = 12,
   parameter int COLD_TH  = 2,
   parameter int INTERVAL = 1000000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_valid,
   input  logic                ev_miss,
   input  logic [SET_W-1:0]    ev_set,
   output logic [NUM_SETS-1:0] hot,
   output logic [NUM_SETS-1:0] cold,
   output logic                interval_end
);
   localparam int IV_W = hcr_pkg::hcr_idx_w(INTERVAL);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [IV_W-1:0] iv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            iv_q <= '0;
      else if (interval_end) iv_q <= '0;
      else                   iv_q <= iv_q + 1'b1;
   end

   assign interval_end = (iv_q == IV_W'(INTERVAL - 1));

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic [CNT_W-1:0] cnt_q;
      logic             bump;

      assign bump = ev_valid && ev_miss && (ev_set == SET_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cnt_q <= '0;
         else if (interval_end)             cnt_q <= '0;
         else if (bump && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end

      assign hot[s]  = (cnt_q >= CNT_W'(HOT_TH));
      assign cold[s] = (cnt_q <= CNT_W'(COLD_TH));
   end
endmodule

// File: rtl/hcr_holder_q.sv
module hcr_holder_q #(
   parameter int NUM_SETS     = 64,
   parameter int WAYS         = 8,
   parameter int FLOAT_BLOCKS = 16,
   parameter int SET_W        = 6,
   parameter int WAY_W        = 3,
   parameter int ENT_W        = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          interval_end,
   input  logic                          move,
   input  logic [ENT_W-1:0]              move_ent,
   input  logic [SET_W-1:0]              move_set,
   input  logic [WAY_W-1:0]              move_way,
   output logic [FLOAT_BLOCKS*SET_W-1:0] ent_set,
   output logic [FLOAT_BLOCKS*WAY_W-1:0] ent_way,
   output logic [FLOAT_BLOCKS-1:0]       ent_pin,
   output logic [NUM_SETS*WAYS-1:0]      way_mode
);
   for (genvar e = 0; e < FLOAT_BLOCKS; e++) begin : g_ent
      logic [SET_W-1:0] set_q;
      logic [WAY_W-1:0] way_q;
      logic             pin_q;
      logic             sel;

      assign sel = move && (move_ent == ENT_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            set_q <= SET_W'(e);
            way_q <= WAY_W'(WAYS - 1);
         end else if (sel) begin
            set_q <= move_set;
            way_q <= move_way;
         end
      end

      // A move in the closing cycle of an interval does not carry its pin over.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            pin_q <= 1'b0;
         else if (interval_end) pin_q <= 1'b0;
         else if (sel)          pin_q <= 1'b1;
      end

      assign ent_set[e*SET_W +: SET_W] = set_q;
      assign ent_way[e*WAY_W +: WAY_W] = way_q;
      assign ent_pin[e]                = pin_q;
   end

   always_comb begin
      way_mode = '0;
      for (int e = 0; e < FLOAT_BLOCKS; e++) begin
         way_mode[int'(ent_set[e*SET_W +: SET_W]) * WAYS
                  + int'(ent_way[e*WAY_W +: WAY_W])] = 1'b1;
      end
   end
endmodule

// File: rtl/hcr_pick.sv
module hcr_pick #(
   parameter int NUM_SETS     = 64,
   parameter int WAYS         = 8,
   parameter int FLOAT_BLOCKS = 16,
   parameter int MAX_SPM      = 2,
   parameter int SET_W        = 6,
   parameter int WAY_W        = 3,
   parameter int ENT_W        = 4
) (
   input  logic [NUM_SETS-1:0]           hot,
   input  logic [NUM_SETS-1:0]           cold,
   input  logic [FLOAT_BLOCKS*SET_W-1:0] ent_set,
   input  logic [FLOAT_BLOCKS*WAY_W-1:0] ent_way,
   input  logic [FLOAT_BLOCKS-1:0]       ent_pin,
   input  logic [NUM_SETS*WAYS-1:0]      way_mode,
   input  logic [NUM_SETS*WAY_W-1:0]     lru_way,
   output logic                          found,
   output logic [ENT_W-1:0]              src_ent,
   output logic [SET_W-1:0]              src_set,
   output logic [WAY_W-1:0]              src_way,
   output logic [SET_W-1:0]              dst_set,
   output logic [WAY_W-1:0]              dst_way
);
   localparam int OCC_W = $clog2(WAYS + 1);

   logic [NUM_SETS-1:0] has_room;
   logic                src_ok;
   logic                dst_ok;
   logic [WAYS-1:0]     dmode;
   logic [WAY_W-1:0]    pref;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_room
      logic [OCC_W-1:0] occ;
      assign occ         = OCC_W'($countones(way_mode[s*WAYS +: WAYS]));
      assign has_room[s] = (occ < OCC_W'(MAX_SPM));
   end

   // Source: lowest entry in a hot set whose block has not moved this interval.
   always_comb begin
      src_ok  = 1'b0;
      src_ent = '0;
      src_set = '0;
      src_way = '0;
      for (int e = FLOAT_BLOCKS - 1; e >= 0; e--) begin
         if (hot[ent_set[e*SET_W +: SET_W]] && !ent_pin[e]) begin
            src_ok  = 1'b1;
            src_ent = ENT_W'(e);
            src_set = ent_set[e*SET_W +: SET_W];
            src_way = ent_way[e*WAY_W +: WAY_W];
         end
      end
   end

   // Destination: lowest cold set with room that is not the source.
   always_comb begin
      dst_ok  = 1'b0;
      dst_set = '0;
      for (int s = NUM_SETS - 1; s >= 0; s--) begin
         if (cold[s] && has_room[s] && (SET_W'(s) != src_set)) begin
            dst_ok  = 1'b1;
            dst_set = SET_W'(s);
         end
      end
   end

   // Victim line: the supplied preference unless it already holds scratchpad.
   always_comb begin
      dmode   = way_mode[int'(dst_set)*WAYS +: WAYS];
      pref    = lru_way[int'(dst_set)*WAY_W +: WAY_W];
      dst_way = pref;
      if (dmode[pref]) begin
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (!dmode[w]) dst_way = WAY_W'(w);
         end
      end
   end

   assign found = src_ok && dst_ok;
endmodule

// File: rtl/hybrid_cache_remapper.sv
module hybrid_cache_remapper #(
   parameter int NUM_SETS     = hcr_pkg::HCR_DEF_SETS,
   parameter int WAYS         = hcr_pkg::HCR_DEF_WAYS,
   parameter int FLOAT_BLOCKS = hcr_pkg::HCR_DEF_FLOATS,
   parameter int MAX_SPM      = 2,
   parameter int CNT_W        = 4,
   parameter int HOT_TH       = 12,
   parameter int COLD_TH      = 2,
   parameter int INTERVAL     = hcr_pkg::HCR_DEF_INTERVAL,
   parameter int SET_W        = $clog2(NUM_SETS),
   parameter int WAY_W        = $clog2(WAYS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ev_valid,
   input  logic                      ev_miss,
   input  logic [SET_W-1:0]          ev_set,
   input  logic [NUM_SETS*WAY_W-1:0] lru_way,
   output logic                      cmd_valid,
   input  logic                      cmd_ready,
   output logic [SET_W-1:0]          cmd_src_set,
   output logic [WAY_W-1:0]          cmd_src_way,
   output logic [SET_W-1:0]          cmd_dst_set,
   output logic [WAY_W-1:0]          cmd_dst_way,
   output logic [NUM_SETS*WAYS-1:0]  way_mode
);
   localparam int ENT_W = hcr_pkg::hcr_idx_w(FLOAT_BLOCKS);

   // Elaboration-time parameter checks.
   if (NUM_SETS < 2 || (1 << SET_W) != NUM_SETS) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (FLOAT_BLOCKS < 1 || FLOAT_BLOCKS > NUM_SETS) begin : g_bad_floats
      $error("FLOAT_BLOCKS must lie in 1..NUM_SETS");
   end
   if (MAX_SPM < 1 || MAX_SPM >= WAYS) begin : g_bad_cap
      $error("MAX_SPM must lie in 1..WAYS-1");
   end
   if (HOT_TH <= COLD_TH || HOT_TH > (1 << CNT_W) - 1) begin : g_bad_th
      $error("need COLD_TH < HOT_TH <= counter maximum");
   end
   if (INTERVAL < 2) begin : g_bad_iv
      $error("INTERVAL must be at least 2");
   end

   logic [NUM_SETS-1:0]           hot;
   logic [NUM_SETS-1:0]           cold;
   logic                          interval_end;
   logic [FLOAT_BLOCKS*SET_W-1:0] ent_set;
   logic [FLOAT_BLOCKS*WAY_W-1:0] ent_way;
   logic [FLOAT_BLOCKS-1:0]       ent_pin;
   logic                          pk_found;
   logic [ENT_W-1:0]              pk_ent;
   logic [SET_W-1:0]              pk_src_set;
   logic [WAY_W-1:0]              pk_src_way;
   logic [SET_W-1:0]              pk_dst_set;
   logic [WAY_W-1:0]              pk_dst_way;
   logic                          accept;
   logic [ENT_W-1:0]              cmd_ent_q;

   hcr_miss_track #(
      .NUM_SETS(NUM_SETS), .SET_W(SET_W), .CNT_W(CNT_W),
      .HOT_TH(HOT_TH), .COLD_TH(COLD_TH), .INTERVAL(INTERVAL)
   ) i_track (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_miss(ev_miss),
      .ev_set(ev_set), .hot(hot), .cold(cold), .interval_end(interval_end)
   );

   hcr_holder_q #(
      .NUM_SETS(NUM_SETS), .WAYS(WAYS), .FLOAT_BLOCKS(FLOAT_BLOCKS),
      .SET_W(SET_W), .WAY_W(WAY_W), .ENT_W(ENT_W)
   ) i_holder (
      .clk(clk), .rst_n(rst_n), .interval_end(interval_end),
      .move(accept), .move_ent(cmd_ent_q), .move_set(cmd_dst_set),
      .move_way(cmd_dst_way), .ent_set(ent_set), .ent_way(ent_way),
      .ent_pin(ent_pin), .way_mode(way_mode)
   );

   hcr_pick #(
      .NUM_SETS(NUM_SETS), .WAYS(WAYS), .FLOAT_BLOCKS(FLOAT_BLOCKS),
      .MAX_SPM(MAX_SPM), .SET_W(SET_W), .WAY_W(WAY_W), .ENT_W(ENT_W)
   ) i_pick (
      .hot(hot), .cold(cold), .ent_set(ent_set), .ent_way(ent_way),
      .ent_pin(ent_pin), .way_mode(way_mode), .lru_way(lru_way),
      .found(pk_found), .src_ent(pk_ent), .src_set(pk_src_set),
      .src_way(pk_src_way), .dst_set(pk_dst_set), .dst_way(pk_dst_way)
   );

   assign accept = cmd_valid && cmd_ready;

   // Command register: loads only when idle, drops for one cycle after an
   // accept so the next choice sees the updated holder list.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid   <= 1'b0;
         cmd_ent_q   <= '0;
         cmd_src_set <= '0;
         cmd_src_way <= '0;
         cmd_dst_set <= '0;
         cmd_dst_way <= '0;
      end else if (accept) begin
         cmd_valid <= 1'b0;
      end else if (!cmd_valid && pk_found) begin
         cmd_valid   <= 1'b1;
         cmd_ent_q   <= pk_ent;
         cmd_src_set <= pk_src_set;
         cmd_src_way <= pk_src_way;
         cmd_dst_set <= pk_dst_set;
         cmd_dst_way <= pk_dst_way;
      end
   end
endmodule

// File: rtl/hcr_remap_chk.sv
module hcr_remap_chk #(
   parameter int NUM_SETS     = 64,
   parameter int WAYS         = 8,
   parameter int FLOAT_BLOCKS = 16,
   parameter int SET_W        = 6,
   parameter int WAY_W        = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cmd_valid,
   input logic                     cmd_ready,
   input logic [SET_W-1:0]         cmd_src_set,
   input logic [WAY_W-1:0]         cmd_src_way,
   input logic [SET_W-1:0]         cmd_dst_set,
   input logic [WAY_W-1:0]         cmd_dst_way,
   input logic [NUM_SETS*WAYS-1:0] way_mode
);
   int   src_idx;
   int   dst_idx;
   logic acc_q;
   int   acc_src_q;
   int   acc_dst_q;

   assign src_idx = int'(cmd_src_set) * WAYS + int'(cmd_src_way);
   assign dst_idx = int'(cmd_dst_set) * WAYS + int'(cmd_dst_way);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= 1'b0;
         acc_src_q <= 0;
         acc_dst_q <= 0;
      end else begin
         acc_q     <= cmd_valid && cmd_ready;
         acc_src_q <= src_idx;
         acc_dst_q <= dst_idx;
      end
   end

   p_conserve_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(way_mode) == FLOAT_BLOCKS);

   p_sets_differ_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_src_set != cmd_dst_set);

   p_dst_is_cache_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (!way_mode[dst_idx] && way_mode[src_idx]));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src_set)
         && $stable(cmd_src_way) && $stable(cmd_dst_set) && $stable(cmd_dst_way)));

   p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q |-> !cmd_valid);

   p_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q |-> (way_mode[acc_dst_q] && !way_mode[acc_src_q]));
endmodule

bind hybrid_cache_remapper hcr_remap_chk #(
   .NUM_SETS(NUM_SETS), .WAYS(WAYS), .FLOAT_BLOCKS(FLOAT_BLOCKS),
   .SET_W(SET_W), .WAY_W(WAY_W)
) i_hcr_remap_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_src_set(cmd_src_set), .cmd_src_way(cmd_src_way),
   .cmd_dst_set(cmd_dst_set), .cmd_dst_way(cmd_dst_way), .way_mode(way_mode)
);

// File: tb/test_hybrid_cache_remapper.sv
`timescale 1ns/1ps
module test_hybrid_cache_remapper;
   localparam int NS = 8, NW = 4, NF = 4, IV = 64;
   localparam int SW = 3, WW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ev_valid = 1'b0, ev_miss = 1'b0;
   logic [SW-1:0] ev_set = '0;
   logic [NS*WW-1:0] lru_way = '0;
   logic          cmd_valid, cmd_ready = 1'b0;
   logic [SW-1:0] cmd_src_set, cmd_dst_set;
   logic [WW-1:0] cmd_src_way, cmd_dst_way;
   logic [NS*NW-1:0] way_mode;

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   hybrid_cache_remapper #(
      .NUM_SETS(NS), .WAYS(NW), .FLOAT_BLOCKS(NF), .MAX_SPM(2), .CNT_W(3),
      .HOT_TH(4), .COLD_TH(1), .INTERVAL(IV)
   ) i_hybrid_cache_remapper (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_miss(ev_miss),
      .ev_set(ev_set), .lru_way(lru_way), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_src_set(cmd_src_set), .cmd_src_way(cmd_src_way),
      .cmd_dst_set(cmd_dst_set), .cmd_dst_way(cmd_dst_way), .way_mode(way_mode)
   );

   // Row fields, 4 bits each: hot set, hot misses, busy set, busy misses,
   // lru for every set, found, src set, src way, dst set, dst way.
   localparam logic [39:0] VEC [6] = '{
      40'h0_4_0_0_2_1_0_3_1_2,   // R3 R4 R5 plain move
      40'h1_5_0_2_3_1_1_3_2_0,   // R5 lru points at scratchpad way
      40'h3_4_1_2_1_1_3_3_0_1,   // R3 lowest cold set below source
      40'h2_4_0_3_0_1_2_3_1_0,   // R3 busy set skipped
      40'h5_6_0_0_0_0_0_0_0_0,   // R4 hot set holds no block
      40'h0_3_0_0_0_0_0_0_0_0    // R2 one miss short of hot
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ev_valid = 1'b0; ev_miss = 1'b0; cmd_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic align(input int phase);
      @(negedge clk);
      while ((cyc % IV) != phase) @(negedge clk);
   endtask

   task automatic events(input int s, input int n, input bit v, input bit m);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ev_valid = v; ev_miss = m; ev_set = SW'(s);
      end
      @(negedge clk);
      ev_valid = 1'b0; ev_miss = 1'b0;
   endtask

   task automatic set_lru(input int l);
      for (int s = 0; s < NS; s++) lru_way[s*WW +: WW] = WW'(l);
   endtask

   task automatic wait_cmd(input int maxc, output bit got);
      got = 1'b0;
      for (int i = 0; i < maxc && !got; i++) begin
         @(negedge clk);
         got = cmd_valid;
      end
   endtask

   task automatic take();
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
   endtask

   task automatic chk_cmd(input string req, input int ss, input int sw,
                          input int ds, input int dw);
      chk(cmd_src_set == SW'(ss), req, "src set", int'(cmd_src_set), ss);
      chk(cmd_src_way == WW'(sw), req, "src way", int'(cmd_src_way), sw);
      chk(cmd_dst_set == SW'(ds), req, "dst set", int'(cmd_dst_set), ds);
      chk(cmd_dst_way == WW'(dw), req, "dst way", int'(cmd_dst_way), dw);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      bit got;
      logic [NS*NW-1:0] snap;

      // R1: reset state
      do_reset();
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
      chk(way_mode == 32'h0000_8888, "R1", "way_mode after reset",
          int'(way_mode), 32'h8888);

      // Table walk
      foreach (VEC[r]) begin
         logic [39:0] v;
         v = VEC[r];
         do_reset();
         align(4);
         set_lru(int'(v[23:20]));
         events(int'(v[31:28]), int'(v[27:24]), 1'b1, 1'b1);
         events(int'(v[39:36]), int'(v[35:32]), 1'b1, 1'b1);
         wait_cmd(10, got);
         chk(got == v[16], "R2", $sformatf("row %0d command presence", r),
             int'(got), int'(v[16]));
         if (got && v[16]) begin
            chk_cmd("R4", int'(v[15:12]), int'(v[11:8]), int'(v[7:4]), int'(v[3:0]));
            take();
            chk(way_mode[int'(v[15:12])*NW + int'(v[11:8])] == 1'b0, "R7",
                "source way back to cache", 1, 0);
            chk(way_mode[int'(v[7:4])*NW + int'(v[3:0])] == 1'b1, "R7",
                "destination way scratchpad", 0, 1);
         end
      end

      // R2: hits and invalid cycles do not count
      do_reset();
      align(4);
      snap = way_mode;
      events(0, 8, 1'b1, 1'b0);
      events(0, 8, 1'b0, 1'b1);
      wait_cmd(10, got);
      chk(!got, "R2", "hits raised a command", int'(got), 0);
      chk(way_mode == snap, "R2", "map after hits", int'(way_mode), int'(snap));

      // R6 then R8: stall, accept, pin
      do_reset();
      align(4);
      set_lru(2);
      events(0, 4, 1'b1, 1'b1);
      wait_cmd(10, got);
      chk(got, "R6", "command for hot set 0", int'(got), 1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(cmd_valid && cmd_src_set == 3'd0 && cmd_dst_set == 3'd1
             && cmd_dst_way == 2'd2, "R6", "stalled command held",
             int'(cmd_dst_set), 1);
      end
      take();
      chk(cmd_valid == 1'b0, "R6", "valid after accept", int'(cmd_valid), 0);
      events(1, 4, 1'b1, 1'b1);
      wait_cmd(10, got);
      chk(got, "R4", "unpinned block of set 1 moves", int'(got), 1);
      chk_cmd("R4", 1, 3, 2, 2);
      take();
      wait_cmd(15, got);
      chk(!got, "R8", "pinned block moved again", int'(got), 0);

      // R9: next interval releases the pin and clears counts
      align(4);
      chk(cmd_valid == 1'b0, "R9", "counts cleared at boundary", int'(cmd_valid), 0);
      events(1, 4, 1'b1, 1'b1);
      wait_cmd(10, got);
      chk(got, "R9", "pin released after boundary", int'(got), 1);
      chk_cmd("R9", 1, 2, 0, 2);
      take();

      // R3: full set skipped as destination
      do_reset();
      align(4);
      set_lru(0);
      events(0, 4, 1'b1, 1'b1);
      wait_cmd(10, got);
      chk_cmd("R3", 0, 3, 1, 0);
      take();
      events(3, 4, 1'b1, 1'b1);
      wait_cmd(10, got);
      chk(got, "R3", "command for hot set 3", int'(got), 1);
      chk_cmd("R3", 3, 3, 2, 0);
      take();

      // R9: misses split across a boundary do not add up
      do_reset();
      align(4);
      events(0, 3, 1'b1, 1'b1);
      align(4);
      events(0, 3, 1'b1, 1'b1);
      wait_cmd(10, got);
      chk(!got, "R9", "counts carried across boundary", int'(got), 0);

      summary();
   end
endmodule